// File: doc/BRIEF.md
# Tri-Port Interleaved Bus Exchanger

This block joins a 16-bit CPU address/data port (X) to two memory ports: an even bank (Y) and an odd bank (Z). Each memory port owns two holding stages. A write stage keeps CPU data for the memory, and a read stage keeps memory data for the CPU. Each stage has its own enable. While an enable is high, the stage passes its input straight through. When the enable goes low, the stage keeps the value it took at the last rising clock edge on which the enable was high. The enables are sampled on the clock, so this is the clocked form of a transparent latch.

A direction input, a bank-select input and two active-low byte enables produce a per-byte output-enable vector for each port. The bidirectional pins are modelled as separate input, output and output-enable vectors.

Bank selection only steers data onto X. It does not gate any capture. One bank can therefore present its held read data on X while the other bank captures its next word, which gives two-way interleaving. With every enable held high, the block acts as a plain bidirectional transceiver.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears all four held values to zero. With every capture enable low, x_out, y_out and z_out then read 0.
- R2: While a write enable (le_xy for Y, le_xz for Z) is high, that port's output equals x_in in the same cycle.
- R3: After a capture enable goes low, the stage output keeps the input value sampled at the last rising clock edge on which the enable was high. Later input changes have no effect.
- R4: x_out shows the Y read stage when path_even is 1 and the Z read stage when path_even is 0.
- R5: The X byte enable x_oe[i] is 1 exactly when dir_tx is 0 and oe_n[i] is 0.
- R6: The byte enable y_oe[i] is 1 exactly when dir_tx=1, path_even=1 and oe_n[i]=0. The byte enable z_oe[i] is 1 exactly when dir_tx=1, path_even=0 and oe_n[i]=0. Y and Z never drive the same byte at the same time.
- R7: Byte lane 0 is bits 7:0 and is controlled by oe_n[0]. Lane 1 is bits 15:8 and is controlled by oe_n[1]. When oe_n is 2'b11, every output enable is 0.
- R8: path_even does not gate capture. A read stage captures while the other bank's held value is on x_out.
- R9: With all four capture enables high, y_out and z_out equal x_in, and x_out equals y_in (path_even=1) or z_in (path_even=0).
- R10: The Y and Z write stages are independent. Capturing into one leaves the other's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 16 | Data arriving on the CPU port |
| y_in | input | 16 | Data arriving on the even memory port |
| z_in | input | 16 | Data arriving on the odd memory port |
| dir_tx | input | 1 | 1: CPU to memory, 0: memory to CPU |
| path_even | input | 1 | 1: even bank Y, 0: odd bank Z |
| oe_n | input | 2 | Active-low byte enables, bit 1 upper |
| le_xy | input | 1 | Y write stage capture enable |
| le_xz | input | 1 | Z write stage capture enable |
| le_yx | input | 1 | Y read stage capture enable |
| le_zx | input | 1 | Z read stage capture enable |
| x_out | output | 16 | Data driven onto the CPU port |
| x_oe | output | 2 | CPU port byte drive enables |
| y_out | output | 16 | Data driven onto the even port |
| y_oe | output | 2 | Even port byte drive enables |
| z_out | output | 16 | Data driven onto the odd port |
| z_oe | output | 2 | Odd port byte drive enables |

## Verification
The bench sweeps all sixteen combinations of direction, bank select and byte enables, and computes each expected enable vector arithmetically. A decoder that swapped the bank sense, ignored a byte lane or let Y and Z drive together would miss there. The interleaved read sequence captures Y, then drives Y onto X while Z captures, then flips the bank. A design that gated capture with the bank select would show stale Z data after the flip. A design that captured on the falling enable instead of the last enabled edge would show the changed input after the enable drops. The bench also checks that capturing one write stage leaves the other untouched, and that a reset in the middle of a run zeroes held data.

// File: rtl/bx_pkg.sv
package bx_pkg;

    localparam int unsigned BX_LANES = 2;

    typedef logic [BX_LANES-1:0] lane_mask_t;

    typedef enum logic {
        DIR_RECV = 1'b0,
        DIR_XMIT = 1'b1
    } dir_e;

    typedef enum logic {
        SEL_ODD  = 1'b0,
        SEL_EVEN = 1'b1
    } bank_e;

    typedef struct packed {
        lane_mask_t cpu;
        lane_mask_t even;
        lane_mask_t odd;
    } oe_set_t;

    function automatic lane_mask_t lane_gate(input logic on, input lane_mask_t req_n);
        return on ? ~req_n : '0;
    endfunction

endpackage

// File: rtl/bx_latch.sv
module bx_latch #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (en) begin
            held <= d;
        end
    end

    // pass-through while open, held value once closed
    assign q = en ? d : held;

endmodule

// File: rtl/bx_oe_decode.sv
module bx_oe_decode
    import bx_pkg::*;
(
    input  dir_e       dir,
    input  bank_e      bank,
    input  lane_mask_t req_n,
    output oe_set_t    oe
);
    logic cpu_on, even_on, odd_on;

    assign cpu_on  = (dir == DIR_RECV);
    assign even_on = (dir == DIR_XMIT) && (bank == SEL_EVEN);
    assign odd_on  = (dir == DIR_XMIT) && (bank == SEL_ODD);

    for (genvar g = 0; g < BX_LANES; g++) begin : g_lane
        lane_mask_t one_hot;
        assign one_hot = lane_mask_t'(1) << g;
        assign oe.cpu[g]  = |(lane_gate(cpu_on,  req_n) & one_hot);
        assign oe.even[g] = |(lane_gate(even_on, req_n) & one_hot);
        assign oe.odd[g]  = |(lane_gate(odd_on,  req_n) & one_hot);
    end

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
    import bx_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANE_W * BX_LANES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   x_in,
    input  logic [DATA_W-1:0]   y_in,
    input  logic [DATA_W-1:0]   z_in,
    input  logic                dir_tx,
    input  logic                path_even,
    input  logic [BX_LANES-1:0] oe_n,
    input  logic                le_xy,
    input  logic                le_xz,
    input  logic                le_yx,
    input  logic                le_zx,
    output logic [DATA_W-1:0]   x_out,
    output logic [BX_LANES-1:0] x_oe,
    output logic [DATA_W-1:0]   y_out,
    output logic [BX_LANES-1:0] y_oe,
    output logic [DATA_W-1:0]   z_out,
    output logic [BX_LANES-1:0] z_oe
);
    dir_e             dir;
    bank_e            bank;
    oe_set_t          oe;
    logic [DATA_W-1:0] rd_even, rd_odd;

    assign dir  = dir_e'(dir_tx);
    assign bank = bank_e'(path_even);

    // CPU-to-memory stages
    bx_latch #(.WIDTH(DATA_W)) u_wr_even (
        .clk(clk), .rst(rst), .en(le_xy), .d(x_in), .q(y_out));
    bx_latch #(.WIDTH(DATA_W)) u_wr_odd (
        .clk(clk), .rst(rst), .en(le_xz), .d(x_in), .q(z_out));

    // memory-to-CPU stages
    bx_latch #(.WIDTH(DATA_W)) u_rd_even (
        .clk(clk), .rst(rst), .en(le_yx), .d(y_in), .q(rd_even));
    bx_latch #(.WIDTH(DATA_W)) u_rd_odd (
        .clk(clk), .rst(rst), .en(le_zx), .d(z_in), .q(rd_odd));

    assign x_out = (bank == SEL_EVEN) ? rd_even : rd_odd;

    bx_oe_decode u_dec (
        .dir(dir), .bank(bank), .req_n(oe_n), .oe(oe));

    assign x_oe = oe.cpu;
    assign y_oe = oe.even;
    assign z_oe = oe.odd;

endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANE_W * bx_pkg::BX_LANES
) (
    input logic                        clk,
    input logic                        rst,
    input logic [DATA_W-1:0]           x_in,
    input logic [DATA_W-1:0]           y_in,
    input logic [DATA_W-1:0]           z_in,
    input logic                        path_even,
    input logic [bx_pkg::BX_LANES-1:0] oe_n,
    input logic                        le_xy,
    input logic                        le_xz,
    input logic                        le_yx,
    input logic                        le_zx,
    input logic [DATA_W-1:0]           x_out,
    input logic [DATA_W-1:0]           y_out,
    input logic [DATA_W-1:0]           z_out,
    input logic [bx_pkg::BX_LANES-1:0] x_oe,
    input logic [bx_pkg::BX_LANES-1:0] y_oe,
    input logic [bx_pkg::BX_LANES-1:0] z_oe
);
    a_r6_no_bank_clash: assert property (@(posedge clk) disable iff (rst)
        (y_oe & z_oe) == '0);

    a_r5_one_direction: assert property (@(posedge clk) disable iff (rst)
        (x_oe != '0) |-> (y_oe == '0 && z_oe == '0));

    a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
        (&oe_n) |-> (x_oe == '0 && y_oe == '0 && z_oe == '0));

    a_r2_even_pass: assert property (@(posedge clk) disable iff (rst)
        le_xy |-> (y_out == x_in));

    a_r3_even_hold: assert property (@(posedge clk) disable iff (rst)
        (!le_xy && $past(!le_xy)) |-> $stable(y_out));

    a_r3_odd_hold: assert property (@(posedge clk) disable iff (rst)
        (!le_xz && $past(!le_xz)) |-> $stable(z_out));

    a_r9_transceiver: assert property (@(posedge clk) disable iff (rst)
        (le_yx && le_zx) |-> (x_out == (path_even ? y_in : z_in)));

endmodule

bind bus_exchanger bus_exchanger_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/bus_exchanger_test.sv
`timescale 1ns/1ps
module bus_exchanger_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] x_in, y_in, z_in;
    logic        dir_tx, path_even;
    logic [1:0]  oe_n;
    logic        le_xy, le_xz, le_yx, le_zx;
    logic [15:0] x_out, y_out, z_out;
    logic [1:0]  x_oe, y_oe, z_oe;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bus_exchanger uut (
        .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .dir_tx(dir_tx), .path_even(path_even), .oe_n(oe_n),
        .le_xy(le_xy), .le_xz(le_xz), .le_yx(le_yx), .le_zx(le_zx),
        .x_out(x_out), .x_oe(x_oe), .y_out(y_out), .y_oe(y_oe),
        .z_out(z_out), .z_oe(z_oe));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at the falling edge, settle, then look
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; x_in = '0; y_in = '0; z_in = '0;
        dir_tx = 1'b0; path_even = 1'b1; oe_n = 2'b11;
        le_xy = 0; le_xz = 0; le_yx = 0; le_zx = 0;
        repeat (3) step();
        rst = 1'b0;
        step(); #1;
        // R1 reset state
        check("R1 x_out even", x_out, 16'h0);
        path_even = 1'b0; #1;
        check("R1 x_out odd", x_out, 16'h0);
        check("R1 y_out", y_out, 16'h0);
        check("R1 z_out", z_out, 16'h0);

        // R5 R6 R7 exhaustive enable sweep, R9 transceiver data
        le_xy = 1; le_xz = 1; le_yx = 1; le_zx = 1;
        for (int c = 0; c < 16; c++) begin
            step();
            dir_tx = c[3]; path_even = c[2]; oe_n = c[1:0];
            x_in = 16'hA000 + 16'(c); y_in = 16'h5100 + 16'(c); z_in = 16'hC300 + 16'(c);
            #1;
            check("R5 x_oe", {14'h0, x_oe}, {14'h0, c[3] ? 2'b00 : ~c[1:0]});
            check("R6 y_oe", {14'h0, y_oe}, {14'h0, (c[3] && c[2]) ? ~c[1:0] : 2'b00});
            check("R6 z_oe", {14'h0, z_oe}, {14'h0, (c[3] && !c[2]) ? ~c[1:0] : 2'b00});
            if (c[1:0] == 2'b11)
                check("R7 idle", {10'h0, x_oe, y_oe, z_oe}, 16'h0);
            check("R9 y_out", y_out, x_in);
            check("R9 z_out", z_out, x_in);
            check("R9 x_out", x_out, c[2] ? y_in : z_in);
        end
        step();
        le_xy = 0; le_xz = 0; le_yx = 0; le_zx = 0;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;

        // R2 R3 R10 write stages
        step(); dir_tx = 1; oe_n = 2'b00; le_xy = 1; x_in = 16'h1234; #1;
        check("R2 y pass", y_out, 16'h1234);
        step(); le_xy = 0; x_in = 16'hBEEF; #1;
        check("R3 y hold", y_out, 16'h1234);
        check("R10 z untouched", z_out, 16'h0);
        step(); le_xz = 1; x_in = 16'h5A5A; #1;
        check("R2 z pass", z_out, 16'h5A5A);
        step(); le_xz = 0; x_in = 16'h0000; #1;
        check("R3 z hold", z_out, 16'h5A5A);
        check("R10 y untouched", y_out, 16'h1234);

        // R4 R8 interleaved read
        step(); dir_tx = 0; path_even = 1; le_yx = 1; y_in = 16'h1111;
        step(); le_yx = 0; y_in = 16'hFFFF; le_zx = 1; z_in = 16'h2222; #1;
        check("R4 x from y", x_out, 16'h1111);
        check("R8 capture while y drives", x_out, 16'h1111);
        check("R5 x drives", {14'h0, x_oe}, 16'h0003);
        step(); le_zx = 0; z_in = 16'h0000; #1;
        check("R8 y still held", x_out, 16'h1111);
        path_even = 0; #1;
        check("R4 x from z", x_out, 16'h2222);
        oe_n = 2'b10; #1;
        check("R7 lower only", {14'h0, x_oe}, 16'h0001);
        oe_n = 2'b01; #1;
        check("R7 upper only", {14'h0, x_oe}, 16'h0002);

        // R1 reset mid-run
        step(); rst = 1; step(); rst = 0; #1;
        check("R1 y cleared", y_out, 16'h0);
        check("R1 x cleared", x_out, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule